// File: doc/BRIEF.md
# Byte-Lane Bus Access Splitter

This block sits between an internal requester and a 16-bit external data bus with a 20-bit byte address. The requester asks for a byte or word read or write. The block turns that request into one or two bus cycles. For each cycle it drives the address, an active-low high-byte enable and address bit 0. Together these two signals pick the active byte lanes, and the block places write data on the lanes that are enabled. A word at an odd address does not fit one aligned bus slot. The block splits it into two cycles and puts the two read bytes back into one result word.

Every bus cycle stays on the bus until the memory side raises `bus_ready`, so wait states come for free. The requester gets a single `req_done` pulse once every cycle of the access has finished. A second bus master can ask for the bus with `hold_req`. It is granted only while no access is in progress and no lock is held. An access issued with `req_lock` raised opens a locked sequence. The lock stays on the bus through the next access that has `req_lock` low, so a read and the write that follows it cannot be separated by the other master.

Top module: `lane_split_bus`

## Requirements
- R1: After reset, `bus_cyc`, `req_done`, `hold_gnt` and `bus_lock` are low, `bus_bhe_n` is high and `req_ready` is high.
- R2: A word access at an even address uses exactly one bus cycle, with `bus_bhe_n` = 0 and `bus_addr[0]` = 0, so both lanes carry data.
- R3: A word access at an odd address uses two bus cycles. The first is at the odd address with `bus_bhe_n` = 0 and `bus_addr[0]` = 1, and carries data bits 7:0 on the high lane (bus bits 15:8). The second is at the address plus one with `bus_bhe_n` = 1 and `bus_addr[0]` = 0, and carries data bits 15:8 on the low lane (bus bits 7:0).
- R4: A byte access at an even address enables only the low lane (`bus_addr[0]` = 0, `bus_bhe_n` = 1). A byte access at an odd address enables only the high lane (`bus_addr[0]` = 1, `bus_bhe_n` = 0). The lane that is not enabled is left unwritten in memory.
- R5: A byte read returns the selected lane in `req_rdata[7:0]` with bits 15:8 zero. A misaligned word read returns the first cycle's high-lane byte in bits 7:0 and the second cycle's low-lane byte in bits 15:8.
- R6: A bus cycle keeps its address and enables stable until `bus_ready` is sampled high. With W wait cycles, an aligned access takes W+2 clocks from acceptance to done, and a split access takes 2W+4 when the memory side inserts one idle clock between cycles.
- R7: `req_done` is a one-clock pulse. It is raised only after the final bus cycle of the access has completed, and never while `bus_cyc` is high.
- R8: `hold_gnt` rises only while no access is in progress. While it is high, `bus_cyc` and `req_ready` are low. It falls one clock after `hold_req` drops.
- R9: An access accepted with `req_lock` = 1 raises `bus_lock`. The lock stays high through the next access that has `req_lock` = 0 and drops after that access completes. While `bus_lock` is high, `hold_req` is not granted.
- R10: The second cycle of a split word at address 0xFFFFF goes to address 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_lock | input | 1 | Open or continue a locked sequence |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result, valid with req_done |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus address; bit 0 is the low-lane select (active low) |
| bus_bhe_n | output | 1 | High-byte lane enable, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both lanes |
| bus_ready | input | 1 | Ends the current bus cycle |
| bus_lock | output | 1 | Locked sequence in progress |
| hold_req | input | 1 | Other master asks for the bus |
| hold_gnt | output | 1 | Bus granted to the other master |

## Verification
The checker watches several rules on every clock. Address and enables must stay stable while a cycle waits. Every cycle must enable at least one lane. The second half of a split word must fall on an even address with only the low lane enabled. `req_done` must be a single pulse clear of bus activity. A grant must never coincide with a bus cycle, with an open request window or with a held lock. Other behaviours can only be shown by the bench's scenarios driving a memory model and reading the results: the bytes that land in memory, the reassembled read values, the cycle counts for each alignment, the latency under wait states, the wrap of the address at the top of the space, and the lock spanning a read and a write while a hold request waits.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC1 = 2'd1,
    ST_CYC2 = 2'd2,
    ST_DONE = 2'd3
  } bls_state_e;
endpackage

// File: rtl/bls_lane_map.sv
// Address, lane enable and write-data steering for the current bus cycle.
module bls_lane_map
  import bls_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              second,
  input  logic              word,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     cyc_addr,
  output logic              cyc_bhe_n,
  output logic [DATA_W-1:0] cyc_wdata
);
  localparam logic [LANE_W-1:0] ZB = '0;

  always_comb begin
    cyc_addr  = addr;
    cyc_bhe_n = 1'b1;
    cyc_wdata = {ZB, wdata[LANE_W-1:0]};
    if (second) begin
      // upper byte of a split word goes to the next (even) address, low lane
      cyc_addr  = addr + AW'(1);
      cyc_bhe_n = 1'b1;
      cyc_wdata = {ZB, wdata[DATA_W-1:LANE_W]};
    end else if (addr[0]) begin
      // odd address: only the high lane carries the low data byte
      cyc_bhe_n = 1'b0;
      cyc_wdata = {wdata[LANE_W-1:0], ZB};
    end else if (word) begin
      cyc_bhe_n = 1'b0;
      cyc_wdata = wdata;
    end
  end
endmodule

// File: rtl/bls_rd_assemble.sv
// Collects read lanes into the result word across one or two cycles.
module bls_rd_assemble
  import bls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic              second,
  input  logic              word,
  input  logic              odd,
  input  logic [DATA_W-1:0] lanes,
  output logic [DATA_W-1:0] result
);
  localparam logic [LANE_W-1:0] ZB = '0;

  logic [DATA_W-1:0] res_q, res_d;
  logic              res_en;

  assign res_en = clr | cap_en;

  always_comb begin
    res_d = res_q;
    if (clr) begin
      res_d = '0;
    end else if (cap_en) begin
      if (second)     res_d = {lanes[LANE_W-1:0], res_q[LANE_W-1:0]};
      else if (odd)   res_d = {ZB, lanes[DATA_W-1:LANE_W]};
      else if (word)  res_d = lanes;
      else            res_d = {ZB, lanes[LANE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/bls_hold_arb.sv
// Grants the bus to another master only between accesses and outside a lock.
module bls_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic locked,
  input  logic hold_req,
  output logic hold_gnt,
  output logic hold_block
);
  logic gnt_q, gnt_d;

  assign hold_block = hold_req & ~locked;

  always_comb begin
    if (gnt_q) gnt_d = hold_req;
    else       gnt_d = idle & hold_req & ~locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign hold_gnt = gnt_q;
endmodule

// File: rtl/lane_split_bus.sv
module lane_split_bus
  import bls_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_lock,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_done,
  output logic [DATA_W-1:0] req_rdata,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_bhe_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              bus_lock,
  input  logic              hold_req,
  output logic              hold_gnt
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  bls_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, word_q, lkreq_q;
  logic              lock_q, lock_d, lock_en;
  logic              accept, idle, hold_block, second, misalign, cap_en;
  logic [AW-1:0]     map_addr;
  logic              map_bhe_n;

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle & ~hold_gnt & ~hold_block;
  assign accept    = req_valid & req_ready;
  assign second    = (state_q == ST_CYC2);
  assign bus_cyc   = (state_q == ST_CYC1) | second;
  assign misalign  = word_q & addr_q[0];
  assign cap_en    = bus_cyc & bus_ready & ~we_q;

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_CYC1;
      ST_CYC1: if (bus_ready) state_d = misalign ? ST_CYC2 : ST_DONE;
      ST_CYC2: if (bus_ready) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      lkreq_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_write;
      word_q  <= req_word;
      lkreq_q <= req_lock;
    end
  end

  // lock: opened by a locked access, closed when an unlocked access ends
  always_comb begin
    lock_en = 1'b0;
    lock_d  = lock_q;
    if (accept && req_lock) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end else if (state_q == ST_DONE && !lkreq_q) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  bls_lane_map #(.AW(AW)) i_lane_map (
    .second    (second),
    .word      (word_q),
    .addr      (addr_q),
    .wdata     (wdata_q),
    .cyc_addr  (map_addr),
    .cyc_bhe_n (map_bhe_n),
    .cyc_wdata (bus_wdata)
  );

  bls_rd_assemble i_rd_assemble (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .clr    (accept),
    .cap_en (cap_en),
    .second (second),
    .word   (word_q),
    .odd    (addr_q[0]),
    .lanes  (bus_rdata),
    .result (req_rdata)
  );

  bls_hold_arb i_hold_arb (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .idle       (idle),
    .locked     (lock_q),
    .hold_req   (hold_req),
    .hold_gnt   (hold_gnt),
    .hold_block (hold_block)
  );

  assign bus_addr  = map_addr;
  assign bus_bhe_n = bus_cyc ? map_bhe_n : 1'b1;
  assign bus_we    = bus_cyc & we_q;
  assign bus_lock  = lock_q;
  assign req_done  = (state_q == ST_DONE);
endmodule

// File: rtl/lane_split_bus_checker.sv
module lane_split_bus_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cyc,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_bhe_n,
  input logic          req_done,
  input logic          req_ready,
  input logic          hold_gnt,
  input logic          bus_lock
);
  a_r6_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_bhe_n)));

  a_r4_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !(bus_bhe_n && bus_addr[0]));

  a_r3_second_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc) && $past(bus_ready)) |-> (bus_bhe_n && !bus_addr[0]));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r7_done_clear_of_bus: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !bus_cyc);

  a_r8_gnt_between: assert property (@(posedge clk) disable iff (!rst_n)
    hold_gnt |-> (!bus_cyc && !req_ready));

  a_r9_gnt_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    hold_gnt |-> !bus_lock);
endmodule

bind lane_split_bus lane_split_bus_checker #(.AW(AW)) i_lane_split_bus_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cyc   (bus_cyc),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_bhe_n (bus_bhe_n),
  .req_done  (req_done),
  .req_ready (req_ready),
  .hold_gnt  (hold_gnt),
  .bus_lock  (bus_lock)
);

// File: tb/test_lane_split_bus.sv
`timescale 1ns/1ps
module test_lane_split_bus;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write, req_word, req_lock;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, req_rdata;
  logic        req_done;
  logic        bus_cyc, bus_we, bus_bhe_n, bus_ready, bus_lock;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        hold_req, hold_gnt;

  int n_chk = 0;
  int n_bad = 0;

  lane_split_bus #(.AW(20)) i_lane_split_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_lock(req_lock), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_lock(bus_lock),
    .hold_req(hold_req), .hold_gnt(hold_gnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: 64 bytes, byte address taken modulo 64
  logic [7:0]  mem [0:63];
  int          mem_wait = 0;
  int          wcnt = 0;
  int          ncyc = 0;
  logic [19:0] log_addr [0:3];
  logic        log_bhe  [0:3];
  logic        log_lock [0:3];

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(8'h40 + i);
    bus_ready = 1'b0;
    bus_rdata = '0;
  end

  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_cyc) begin
      if (wcnt >= mem_wait) begin
        automatic int base = {bus_addr[5:1], 1'b0};
        bus_rdata = {mem[base+1], mem[base]};
        if (bus_we) begin
          if (!bus_addr[0]) mem[base]   = bus_wdata[7:0];
          if (!bus_bhe_n)   mem[base+1] = bus_wdata[15:8];
        end
        if (ncyc < 4) begin
          log_addr[ncyc] = bus_addr;
          log_bhe[ncyc]  = bus_bhe_n;
          log_lock[ncyc] = bus_lock;
        end
        ncyc++;
        bus_ready = 1'b1;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic we, input logic word, input logic lock,
                           input logic [19:0] a, input logic [15:0] wd,
                           output logic [15:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ncyc = 0;
    req_valid = 1'b1; req_write = we; req_word = word; req_lock = lock;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!req_done) begin
      @(negedge clk);
      lat++;
    end
    rd = req_rdata;
    @(negedge clk);
    chk(req_done == 1'b0, "R7 done single pulse", 32'(req_done), 32'h0);
  endtask

  task automatic t_reset();
    chk(bus_cyc == 1'b0,   "R1 bus_cyc",  32'(bus_cyc), 0);
    chk(req_done == 1'b0,  "R1 req_done", 32'(req_done), 0);
    chk(hold_gnt == 1'b0,  "R1 hold_gnt", 32'(hold_gnt), 0);
    chk(bus_lock == 1'b0,  "R1 bus_lock", 32'(bus_lock), 0);
    chk(bus_bhe_n == 1'b1, "R1 bus_bhe_n", 32'(bus_bhe_n), 1);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_even_word();
    logic [15:0] rd; int lat;
    do_access(1'b1, 1'b1, 1'b0, 20'h00010, 16'hBEEF, rd, lat);
    chk(ncyc == 1, "R2 cycle count", 32'(ncyc), 1);
    chk(log_bhe[0] == 1'b0 && log_addr[0] == 20'h00010, "R2 lanes",
        {11'h0, log_bhe[0], log_addr[0]}, 32'h00010);
    chk({mem[17], mem[16]} == 16'hBEEF, "R2 memory", {mem[17], mem[16]}, 32'hBEEF);
    do_access(1'b0, 1'b1, 1'b0, 20'h00010, 16'h0, rd, lat);
    chk(rd == 16'hBEEF && ncyc == 1, "R2 read back", 32'(rd), 32'hBEEF);
  endtask

  task automatic t_odd_word();
    logic [15:0] rd; int lat;
    do_access(1'b1, 1'b1, 1'b0, 20'h00021, 16'h1234, rd, lat);
    chk(ncyc == 2, "R3 cycle count", 32'(ncyc), 2);
    chk(log_addr[0] == 20'h00021 && log_bhe[0] == 1'b0, "R3 first cycle",
        {11'h0, log_bhe[0], log_addr[0]}, 32'h00021);
    chk(log_addr[1] == 20'h00022 && log_bhe[1] == 1'b1, "R3 second cycle",
        {11'h0, log_bhe[1], log_addr[1]}, 32'h100022);
    chk(mem[33] == 8'h34 && mem[34] == 8'h12, "R3 memory bytes", {mem[34], mem[33]}, 32'h1234);
    chk(mem[32] == 8'h60 && mem[35] == 8'h63, "R3 neighbours untouched", {mem[35], mem[32]}, 32'h6360);
    do_access(1'b0, 1'b1, 1'b0, 20'h00021, 16'h0, rd, lat);
    chk(rd == 16'h1234, "R5 misaligned reassembly", 32'(rd), 32'h1234);
  endtask

  task automatic t_bytes();
    logic [15:0] rd; int lat;
    do_access(1'b1, 1'b0, 1'b0, 20'h00008, 16'hFFA5, rd, lat);
    chk(log_bhe[0] == 1'b1 && log_addr[0][0] == 1'b0 && ncyc == 1, "R4 even byte lanes",
        {30'h0, log_bhe[0], log_addr[0][0]}, 32'h2);
    chk(mem[8] == 8'hA5 && mem[9] == 8'h49, "R4 even byte memory", {mem[9], mem[8]}, 32'h49A5);
    do_access(1'b1, 1'b0, 1'b0, 20'h0000B, 16'hFF5A, rd, lat);
    chk(log_bhe[0] == 1'b0 && log_addr[0][0] == 1'b1 && ncyc == 1, "R4 odd byte lanes",
        {30'h0, log_bhe[0], log_addr[0][0]}, 32'h1);
    chk(mem[11] == 8'h5A && mem[10] == 8'h4A, "R4 odd byte memory", {mem[11], mem[10]}, 32'h5A4A);
    do_access(1'b0, 1'b0, 1'b0, 20'h0000B, 16'h0, rd, lat);
    chk(rd == 16'h005A, "R5 odd byte read", 32'(rd), 32'h005A);
    do_access(1'b0, 1'b0, 1'b0, 20'h00008, 16'h0, rd, lat);
    chk(rd == 16'h00A5, "R5 even byte read", 32'(rd), 32'h00A5);
  endtask

  task automatic t_wait();
    logic [15:0] rd; int lat;
    mem_wait = 2;
    do_access(1'b0, 1'b1, 1'b0, 20'h00004, 16'h0, rd, lat);
    chk(lat == 4, "R6 aligned latency", 32'(lat), 4);
    chk(rd == 16'h4544, "R6 aligned data", 32'(rd), 32'h4544);
    do_access(1'b0, 1'b1, 1'b0, 20'h00005, 16'h0, rd, lat);
    chk(lat == 8, "R6 split latency", 32'(lat), 8);
    chk(rd == 16'h4645, "R5 split data under waits", 32'(rd), 32'h4645);
    mem_wait = 0;
  endtask

  task automatic t_hold();
    @(negedge clk);
    hold_req = 1'b1;
    @(negedge clk);
    chk(hold_gnt == 1'b1 && req_ready == 1'b0, "R8 idle grant", {hold_gnt, req_ready}, 32'h2);
    hold_req = 1'b0;
    @(negedge clk);
    chk(hold_gnt == 1'b0 && req_ready == 1'b1, "R8 release", {hold_gnt, req_ready}, 32'h1);
  endtask

  task automatic t_hold_mid();
    bit early = 1'b0;
    mem_wait = 3;
    @(negedge clk);
    ncyc = 0;
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_lock = 1'b0;
    req_addr = 20'h00003; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    hold_req = 1'b1;
    while (!req_done) begin
      if (hold_gnt) early = 1'b1;
      @(negedge clk);
    end
    chk(!early && ncyc == 2, "R8 no grant during access", {31'h0, early}, 0);
    @(negedge clk);
    @(negedge clk);
    chk(hold_gnt == 1'b1, "R8 grant after access", 32'(hold_gnt), 1);
    hold_req = 1'b0;
    @(negedge clk);
    mem_wait = 0;
  endtask

  task automatic t_lock();
    logic [15:0] rd; int lat;
    do_access(1'b0, 1'b1, 1'b1, 20'h00030, 16'h0, rd, lat);
    chk(rd == 16'h7170, "R9 locked read data", 32'(rd), 32'h7170);
    chk(bus_lock == 1'b1, "R9 lock held after read", 32'(bus_lock), 1);
    hold_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold_gnt == 1'b0 && req_ready == 1'b1, "R9 hold refused while locked",
        {hold_gnt, req_ready}, 32'h1);
    do_access(1'b1, 1'b1, 1'b0, 20'h00030, 16'h0102, rd, lat);
    chk(log_lock[0] == 1'b1, "R9 lock during write", 32'(log_lock[0]), 1);
    chk(bus_lock == 1'b0, "R9 lock released", 32'(bus_lock), 0);
    @(negedge clk);
    chk(hold_gnt == 1'b1, "R9 grant after unlock", 32'(hold_gnt), 1);
    hold_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_wrap();
    logic [15:0] rd; int lat;
    do_access(1'b1, 1'b1, 1'b0, 20'hFFFFF, 16'hCAFE, rd, lat);
    chk(log_addr[0] == 20'hFFFFF, "R10 first address", 32'(log_addr[0]), 32'hFFFFF);
    chk(log_addr[1] == 20'h00000 && ncyc == 2, "R10 wrapped address", 32'(log_addr[1]), 0);
    chk(mem[63] == 8'hFE && mem[0] == 8'hCA, "R10 memory", {mem[0], mem[63]}, 32'hCAFE);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0; req_lock = 1'b0;
    req_addr = '0; req_wdata = '0; hold_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_even_word();
    t_odd_word();
    t_bytes();
    t_wait();
    t_hold();
    t_hold_mid();
    t_lock();
    t_wrap();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule